// File: doc/BRIEF.md
# Byte-Command Register Access Engine

This block turns a stream of bytes from a link receiver into accesses on an internal 8-bit register bus, and sends the bytes that are read back to a link transmitter. Every transaction opens with a command byte. Bit 7 of that byte picks the direction: 1 is a read and 0 is a write. Bits 6:0 pick one of 128 byte-wide locations. Both the receive and the transmit stream use a valid/ready byte handshake.

A parameter mask sorts each location into one of two kinds. A register moves exactly one data byte per command. A port acts like a FIFO: the byte after the command gives a count N, and then N data bytes stream to or from that same address, which does not advance. During a read, the engine refuses new input until the transmitter has taken the last response byte.

Top module: `cmd_access_engine`

## Requirements
- R1: After reset, rx_ready is 1 and tx_valid, bus_wr_en and bus_rd_en are 0.
- R2: Command byte bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 6:0 are presented on bus_addr for every data access of that command.
- R3: A write command to a register accepts exactly one following byte. In the cycle that byte is accepted, it produces one bus_wr_en pulse with that byte on bus_wr_data. The next accepted byte is treated as a new command.
- R4: A read command to a register produces one bus_rd_en pulse. The bus_rd_data value of that cycle is returned as a single tx byte.
- R5: An address is a port when PORT_MASK[address] is 1; by default this holds for addresses 0x40 to 0x7F. For a port write, the byte after the command is the count N, and the next N bytes are written in order to that one address.
- R6: A port read with count N returns exactly N bytes on tx, in the order of the N bus reads, all at the same address.
- R7: A port command with count 0 moves no data, and the next byte is a new command.
- R8: From the acceptance of a read command until its last response byte has been taken by the transmitter, rx_ready stays 0.
- R9: While tx_valid is 1 and tx_ready is 0, tx_valid stays 1 and tx_data does not change.
- R10: bus_rd_en is never asserted while a response byte is held that the transmitter is not taking in that cycle.
- R11: Asserting rst_n low in the middle of a transaction drops it. After reset, the next byte received is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receive byte present |
| rx_ready | output | 1 | Engine accepts the receive byte |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | Response byte present |
| tx_ready | input | 1 | Transmitter takes the response byte |
| tx_data | output | 8 | Response byte |
| bus_addr | output | 7 | Internal location address |
| bus_wr_en | output | 1 | Write strobe, one per data byte |
| bus_wr_data | output | 8 | Write data |
| bus_rd_en | output | 1 | Read strobe, one per response byte |
| bus_rd_data | input | 8 | Read data, valid in the cycle of bus_rd_en |

## Verification
In a multi-byte port read, the transmitter can take the held response byte in the same cycle that the engine fetches the next byte from the bus into that same holding register. The bench provokes this by running port reads while tx_ready is held high and also while it is randomly toggled. Every returned sequence is compared with the bench's own per-address read model. A bench monitor also counts any fetch that lands while a stalled byte is still held (R10).

// File: rtl/cae_pkg.sv
package cae_pkg;

  typedef enum logic [2:0] {
    CAE_IDLE  = 3'd0,
    CAE_COUNT = 3'd1,
    CAE_WRITE = 3'd2,
    CAE_READ  = 3'd3,
    CAE_DRAIN = 3'd4
  } cae_state_e;

endpackage

// File: rtl/cae_rst_sync.sv
module cae_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/cae_xfer_counter.sv
module cae_xfer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);

  logic [CNT_W-1:0] remain_q, remain_d;
  logic             remain_en;

  always_comb begin
    remain_en = load | dec;
    remain_d  = remain_q;
    if (load)     remain_d = load_val;
    else if (dec) remain_d = remain_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  assign last = (remain_q == CNT_W'(1));

endmodule

// File: rtl/cae_tx_hold.sv
module cae_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              slot_free,
  output logic              fire
);

  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    fire      = full_q & tx_ready;
    slot_free = ~full_q | tx_ready;
    if (load)      full_d = 1'b1;
    else if (fire) full_d = 1'b0;
    else           full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= load_data;
  end

  assign tx_valid = full_q;
  assign tx_data  = data_q;

endmodule

// File: rtl/cae_ctrl.sv
module cae_ctrl
  import cae_pkg::*;
#(
  parameter int                         DATA_W    = 8,
  parameter int                         CNT_W     = 8,
  parameter logic [(1<<(DATA_W-1))-1:0] PORT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              tx_slot_free,
  input  logic              tx_fire,
  input  logic              cnt_last,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              cnt_dec,
  output logic [DATA_W-2:0] bus_addr,
  output logic              bus_wr_en,
  output logic              bus_rd_en,
  output logic              tx_load
);

  localparam int ADDR_W = DATA_W - 1;

  cae_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              cmd_en;
  logic              rx_fire;

  always_comb begin
    state_d      = state_q;
    rx_ready     = 1'b0;
    cmd_en       = 1'b0;
    cnt_load     = 1'b0;
    cnt_load_val = CNT_W'(1);
    cnt_dec      = 1'b0;
    bus_wr_en    = 1'b0;
    bus_rd_en    = 1'b0;
    tx_load      = 1'b0;
    rx_fire      = 1'b0;
    unique case (state_q)
      CAE_IDLE: begin
        rx_ready = 1'b1;
        rx_fire  = rx_valid;
        if (rx_fire) begin
          cmd_en = 1'b1;
          if (PORT_MASK[rx_data[ADDR_W-1:0]]) begin
            state_d = CAE_COUNT;
          end else begin
            cnt_load = 1'b1;
            state_d  = rx_data[DATA_W-1] ? CAE_READ : CAE_WRITE;
          end
        end
      end
      CAE_COUNT: begin
        rx_ready = 1'b1;
        rx_fire  = rx_valid;
        if (rx_fire) begin
          if (rx_data == '0) begin
            state_d = CAE_IDLE;
          end else begin
            cnt_load     = 1'b1;
            cnt_load_val = CNT_W'(rx_data);
            state_d      = rd_q ? CAE_READ : CAE_WRITE;
          end
        end
      end
      CAE_WRITE: begin
        rx_ready = 1'b1;
        rx_fire  = rx_valid;
        if (rx_fire) begin
          bus_wr_en = 1'b1;
          cnt_dec   = 1'b1;
          if (cnt_last) state_d = CAE_IDLE;
        end
      end
      CAE_READ: begin
        if (tx_slot_free) begin
          bus_rd_en = 1'b1;
          tx_load   = 1'b1;
          cnt_dec   = 1'b1;
          if (cnt_last) state_d = CAE_DRAIN;
        end
      end
      CAE_DRAIN: begin
        if (tx_fire) state_d = CAE_IDLE;
      end
      default: state_d = CAE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CAE_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else if (cmd_en) begin
      addr_q <= rx_data[ADDR_W-1:0];
      rd_q   <= rx_data[DATA_W-1];
    end
  end

  assign bus_addr = addr_q;

endmodule

// File: rtl/cmd_access_engine.sv
module cmd_access_engine #(
  parameter int                         DATA_W     = 8,
  parameter int                         CNT_W      = 8,
  parameter int                         RST_STAGES = 2,
  parameter logic [(1<<(DATA_W-1))-1:0] PORT_MASK  =
    {{(1<<(DATA_W-2)){1'b1}}, {(1<<(DATA_W-2)){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-2:0] bus_addr,
  output logic              bus_wr_en,
  output logic [DATA_W-1:0] bus_wr_data,
  output logic              bus_rd_en,
  input  logic [DATA_W-1:0] bus_rd_data
);

  logic             rst_sn;
  logic             tx_slot_free;
  logic             tx_fire;
  logic             tx_load;
  logic             cnt_last;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_load_val;
  logic             cnt_dec;

  cae_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  cae_ctrl #(
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .PORT_MASK (PORT_MASK)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_sn),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_ready     (rx_ready),
    .tx_slot_free (tx_slot_free),
    .tx_fire      (tx_fire),
    .cnt_last     (cnt_last),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .cnt_dec      (cnt_dec),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .tx_load      (tx_load)
  );

  cae_xfer_counter #(.CNT_W(CNT_W)) i_counter (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .last     (cnt_last)
  );

  cae_tx_hold #(.DATA_W(DATA_W)) i_tx_hold (
    .clk       (clk),
    .rst_n     (rst_sn),
    .load      (tx_load),
    .load_data (bus_rd_data),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .slot_free (tx_slot_free),
    .fire      (tx_fire)
  );

  assign bus_wr_data = rx_data;

endmodule

// File: rtl/cae_checker.sv
module cae_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              bus_wr_en,
  input logic              bus_rd_en
);

  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |-> (!tx_valid || tx_ready));

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r8_rx_closed_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |-> !rx_ready);

  a_r3_write_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr_en |-> (rx_valid && rx_ready));

  a_r4_read_fills_tx: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> tx_valid);

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_rd_en));

endmodule

bind cmd_access_engine cae_checker #(.DATA_W(DATA_W)) i_cae_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en)
);

// File: tb/test_cmd_access_engine.sv
`timescale 1ns/1ps
module test_cmd_access_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid;
  logic       rx_ready;
  logic [7:0] rx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] tx_data;
  logic [6:0] bus_addr;
  logic       bus_wr_en;
  logic [7:0] bus_wr_data;
  logic       bus_rd_en;
  logic [7:0] bus_rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int r10_bad = 0;
  int tx_mode = 2;
  bit done = 0;
  int rd_cnt [128];
  int rd_exp [128];
  logic [14:0] wr_log [$];
  logic [14:0] exp_wr [$];
  logic [7:0]  tx_log [$];
  logic [7:0]  exp_tx [$];

  always #2.5 clk = ~clk;

  cmd_access_engine i_cmd_access_engine (
    .clk (clk), .rst_n (rst_n),
    .rx_valid (rx_valid), .rx_ready (rx_ready), .rx_data (rx_data),
    .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
    .bus_addr (bus_addr), .bus_wr_en (bus_wr_en), .bus_wr_data (bus_wr_data),
    .bus_rd_en (bus_rd_en), .bus_rd_data (bus_rd_data)
  );

  function automatic logic [7:0] rd_val(input logic [6:0] a, input int k);
    return 8'(int'(a) * 3 + k * 17 + 'h5A);
  endfunction

  function automatic bit is_port(input logic [6:0] a);
    return a[6];
  endfunction

  assign bus_rd_data = rd_val(bus_addr, rd_cnt[bus_addr]);

  always @(posedge clk) begin
    if (bus_wr_en) wr_log.push_back({bus_addr, bus_wr_data});
    if (bus_rd_en) rd_cnt[bus_addr] <= rd_cnt[bus_addr] + 1;
    if (tx_valid && tx_ready) tx_log.push_back(tx_data);
    if (bus_rd_en && tx_valid && !tx_ready) r10_bad++;
  end

  always @(negedge clk) begin
    case (tx_mode)
      0:       tx_ready <= ($urandom % 3) != 0;
      1:       tx_ready <= 1'b0;
      default: tx_ready <= 1'b1;
    endcase
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    if (tx_mode == 0 && ($urandom % 4) == 0) begin
      rx_valid = 1'b0;
      @(negedge clk);
    end
    rx_valid = 1'b1;
    rx_data  = b;
    do @(posedge clk); while (!rx_ready);
  endtask

  task automatic rx_idle;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] d);
    send_byte({1'b0, a});
    send_byte(d);
    exp_wr.push_back({a, d});
    rx_idle();
  endtask

  task automatic port_write(input logic [6:0] a, input int n);
    send_byte({1'b0, a});
    send_byte(8'(n));
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      send_byte(d);
      exp_wr.push_back({a, d});
    end
    rx_idle();
  endtask

  task automatic do_read(input logic [6:0] a, input int n);
    send_byte({1'b1, a});
    if (is_port(a)) send_byte(8'(n));
    for (int k = 0; k < n; k++) begin
      exp_tx.push_back(rd_val(a, rd_exp[a]));
      rd_exp[a]++;
    end
    rx_idle();
  endtask

  task automatic wait_and_compare(input string req);
    for (int t = 0; t < 4000 && tx_log.size() < exp_tx.size(); t++)
      @(negedge clk);
    repeat (4) @(negedge clk);
    check(wr_log.size() == exp_wr.size(), req, "write count",
          wr_log.size(), exp_wr.size());
    for (int i = 0; i < wr_log.size() && i < exp_wr.size(); i++)
      check(wr_log[i] == exp_wr[i], req, "write addr/data",
            int'(wr_log[i]), int'(exp_wr[i]));
    check(tx_log.size() == exp_tx.size(), req, "read byte count",
          tx_log.size(), exp_tx.size());
    for (int i = 0; i < tx_log.size() && i < exp_tx.size(); i++)
      check(tx_log[i] == exp_tx[i], req, "read byte",
            int'(tx_log[i]), int'(exp_tx[i]));
    wr_log.delete(); exp_wr.delete(); tx_log.delete(); exp_tx.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h51C0DE));
    for (int i = 0; i < 128; i++) begin rd_cnt[i] = 0; rd_exp[i] = 0; end
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(rx_ready == 1'b1, "R1", "rx_ready", rx_ready, 1);
    check(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
    check(bus_wr_en == 1'b0 && bus_rd_en == 1'b0, "R1", "bus strobes",
          {bus_wr_en, bus_rd_en}, 0);

    // R2 R3 register writes, R4 register read
    reg_write(7'h05, 8'hC3);
    reg_write(7'h3F, 8'h00);
    wait_and_compare("R3");
    do_read(7'h05, 1);
    do_read(7'h22, 1);
    wait_and_compare("R4");

    // R5 port write burst, R6 port read with back-to-back fetch and drain
    port_write(7'h41, 7);
    wait_and_compare("R5");
    do_read(7'h7E, 9);
    wait_and_compare("R6");

    // R7 zero counts
    send_byte({1'b0, 7'h60}); send_byte(8'h00);
    reg_write(7'h12, 8'h3C);
    send_byte({1'b1, 7'h61}); send_byte(8'h00);
    do_read(7'h13, 1);
    wait_and_compare("R7");

    // R8 R9 stalled transmitter on a port read
    tx_mode = 1;
    do_read(7'h45, 3);
    repeat (2) @(negedge clk);
    held = tx_data;
    rx_valid = 1'b1; rx_data = {1'b0, 7'h10};
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      check(rx_ready == 1'b0, "R8", "rx_ready during read", rx_ready, 0);
      check(tx_valid == 1'b1 && tx_data == held, "R9", "held tx byte",
            tx_data, held);
    end
    rx_valid = 1'b0;
    tx_mode = 2;
    wait_and_compare("R8");

    // R11 reset in the middle of a port write
    send_byte({1'b0, 7'h50}); send_byte(8'd5);
    send_byte(8'hA1); exp_wr.push_back({7'h50, 8'hA1});
    send_byte(8'hA2); exp_wr.push_back({7'h50, 8'hA2});
    @(negedge clk);
    rx_valid = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_ready == 1'b1 && tx_valid == 1'b0, "R11", "idle after reset",
          {rx_ready, tx_valid}, 2);
    reg_write(7'h11, 8'hA5);
    wait_and_compare("R11");

    // random mix, R5 R6 R2
    tx_mode = 0;
    for (int it = 0; it < 40; it++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom);
      n = is_port(a) ? 1 + int'($urandom % 6) : 1;
      if ($urandom % 2) do_read(a, n);
      else if (is_port(a)) port_write(a, n);
      else reg_write(a, 8'($urandom));
      wait_and_compare("R2 R5 R6");
    end
    tx_mode = 2;
    check(r10_bad == 0, "R10", "fetch over stalled byte", r10_bad, 0);
    report();
  end

endmodule